// File: doc/BRIEF.md
# Error Interrupt Status Aggregator

This block gathers six controller error events into one sticky status word and turns them into two interrupt lines for a host processor. Each source arrives as a one-cycle pulse and sets its own status bit, whether or not that source is enabled. A per-source enable word gates the status into a masked view. The single error interrupt is the OR of that masked view. A separate fatal line covers only the sources that belong to the fatal class.

Software reaches the block through a simple register port with a combinational read. Four word offsets are decoded:

| Offset | View |
|---|---|
| 0x1c0 | raw status |
| 0x1c4 | masked status |
| 0x1c8 | enable set alias |
| 0x1cc | enable clear alias |

Status bits are cleared by writing ones. The enable word is changed only through its set and clear aliases, so no read-modify-write is needed. An event that arrives in the same cycle as its clear wins, so no error is lost.

The asynchronous active-low reset is released synchronously inside the block. Registers stay in reset for two clock edges after `rst_n` rises.

Top module: `eia_err_irq_agg`

## Requirements
- R1: After reset, raw status and the enable word are zero, every offset reads zero, and `err_irq_o` and `err_fatal_o` are low.
- R2: A one-cycle pulse on `err_evt_i[i]` sets raw status bit i at the next clock edge, whatever the enable state. The bit-to-source map is:
  - bit 0: system error
  - bit 1: fatal error
  - bit 2: non-fatal error
  - bit 3: correctable error
  - bit 4: AXI tag lookup fatal
  - bit 5: ECRC error
- R3: A read at offset 0x1c0 returns raw status in bits 5..0. A read at offset 0x1c4 returns raw status AND the enable word.
- R4: A write to offset 0x1c0 or offset 0x1c4 clears each raw bit whose data bit is 1 and leaves the other raw bits unchanged. Without events or writes, raw status holds.
- R5: A write to 0x1c8 ORs data bits 5..0 into the enable word, and a write of 0x3f enables every source. A write to 0x1cc clears each enable bit whose data bit is 1. Reads at either offset return the enable word.
- R6: An event that arrives in the same cycle as a write clearing its bit leaves the bit set.
- R7: `err_irq_o` is high exactly when the masked status is non-zero.
- R8: `err_fatal_o` is high exactly when masked bit 1 or masked bit 4 is set.
- R9: Read data bits 31..6 are always zero, and data bits 31..6 of a write have no effect. Any offset other than the four above reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | 6 | One-cycle error event pulses, one per source |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| err_irq_o | output | 1 | Error interrupt: OR of masked status |
| err_fatal_o | output | 1 | Fatal indication: OR of masked fatal-class bits |

## Verification
The bench builds the block with its default parameters: six sources, a 32-bit data word, a 12-bit offset and a fatal class of bits 1 and 4. With six sources, every one of the 64 enable words can be crossed with every one of the 64 event patterns. For each pair, the raw view, the masked view and both interrupt lines are checked against values the bench computes arithmetically. Directed steps add the following:
- clears through both status offsets;
- accumulation and removal of enables through the two aliases;
- a clear that collides with a new event;
- writes to the upper data bits and to an unmapped offset.

// File: rtl/eia_pkg.sv
package eia_pkg;

  // Word offsets decoded by the register port (software depends on them).
  localparam int unsigned OFS_RAW    = 32'h1c0;
  localparam int unsigned OFS_MASKED = 32'h1c4;
  localparam int unsigned OFS_ARM    = 32'h1c8;
  localparam int unsigned OFS_DISARM = 32'h1cc;

  // Which register the current offset selects.
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_RAW    = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_ARM    = 3'd3,
    SEL_DISARM = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/eia_rst_sync.sv
module eia_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/eia_regdec.sv
module eia_regdec
  import eia_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [N_SRC-1:0]  raw_i,
  input  logic [N_SRC-1:0]  en_i,
  output logic [N_SRC-1:0]  clr_mask_o,
  output logic [N_SRC-1:0]  arm_mask_o,
  output logic [N_SRC-1:0]  disarm_mask_o,
  output logic [DATA_W-1:0] bus_rdata_o
);

  localparam int PAD_W = DATA_W - N_SRC;

  reg_sel_e         sel;
  logic [N_SRC-1:0] wbits;
  logic [N_SRC-1:0] rbits;

  // Offset decode
  always_comb begin
    if (bus_addr_i == ADDR_W'(OFS_RAW)) begin
      sel = SEL_RAW;
    end else if (bus_addr_i == ADDR_W'(OFS_MASKED)) begin
      sel = SEL_MASKED;
    end else if (bus_addr_i == ADDR_W'(OFS_ARM)) begin
      sel = SEL_ARM;
    end else if (bus_addr_i == ADDR_W'(OFS_DISARM)) begin
      sel = SEL_DISARM;
    end else begin
      sel = SEL_NONE;
    end
  end

  // Only the low N_SRC data bits ever reach state.
  assign wbits = bus_wdata_i[N_SRC-1:0];

  // Write strobes
  always_comb begin
    clr_mask_o    = '0;
    arm_mask_o    = '0;
    disarm_mask_o = '0;
    if (bus_wr_i) begin
      unique case (sel)
        SEL_RAW, SEL_MASKED: clr_mask_o    = wbits;
        SEL_ARM:             arm_mask_o    = wbits;
        SEL_DISARM:          disarm_mask_o = wbits;
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    unique case (sel)
      SEL_RAW:             rbits = raw_i;
      SEL_MASKED:          rbits = raw_i & en_i;
      SEL_ARM, SEL_DISARM: rbits = en_i;
      default:             rbits = '0;
    endcase
  end

  assign bus_rdata_o = {{PAD_W{1'b0}}, rbits};

endmodule

// File: rtl/eia_status.sv
module eia_status #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] raw_o
);

  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] raw_d;
  logic [N_SRC-1:0] raw_ce;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // Next state: a new event wins over a clear in the same cycle.
    always_comb begin
      raw_ce[i] = evt_i[i] | clr_i[i];
      raw_d[i]  = evt_i[i] | (raw_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[i] <= 1'b0;
      end else if (raw_ce[i]) begin
        raw_q[i] <= raw_d[i];
      end
    end
  end

  assign raw_o = raw_q;

endmodule

// File: rtl/eia_enable.sv
module eia_enable #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] arm_i,
  input  logic [N_SRC-1:0] disarm_i,
  output logic [N_SRC-1:0] en_o
);

  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] en_d;
  logic             en_ce;

  // Next state
  always_comb begin
    en_ce = (|arm_i) | (|disarm_i);
    en_d  = (en_q | arm_i) & ~disarm_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/eia_irq_out.sv
module eia_irq_out #(
  parameter int               N_SRC     = 6,
  parameter logic [N_SRC-1:0] FATAL_SEL = 6'b01_0010
) (
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o,
  output logic             fatal_o
);

  logic [N_SRC-1:0] gated;

  always_comb begin
    gated   = raw_i & en_i;
    irq_o   = |gated;
    fatal_o = |(gated & FATAL_SEL);
  end

endmodule

// File: rtl/eia_err_irq_agg.sv
module eia_err_irq_agg #(
  parameter int               N_SRC     = 6,
  parameter int               DATA_W    = 32,
  parameter int               ADDR_W    = 12,
  parameter int               SYNC_STG  = 2,
  parameter logic [N_SRC-1:0] FATAL_SEL = 6'b01_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  err_evt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              err_irq_o,
  output logic              err_fatal_o
);

  logic             rst_sync_n;
  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] clr_mask;
  logic [N_SRC-1:0] arm_mask;
  logic [N_SRC-1:0] disarm_mask;

  eia_rst_sync #(
    .STAGES (SYNC_STG)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eia_regdec #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dec (
    .bus_addr_i    (bus_addr_i),
    .bus_wr_i      (bus_wr_i),
    .bus_wdata_i   (bus_wdata_i),
    .raw_i         (raw_q),
    .en_i          (en_q),
    .clr_mask_o    (clr_mask),
    .arm_mask_o    (arm_mask),
    .disarm_mask_o (disarm_mask),
    .bus_rdata_o   (bus_rdata_o)
  );

  eia_status #(
    .N_SRC (N_SRC)
  ) u_status (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt_i (err_evt_i),
    .clr_i (clr_mask),
    .raw_o (raw_q)
  );

  eia_enable #(
    .N_SRC (N_SRC)
  ) u_enable (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .arm_i    (arm_mask),
    .disarm_i (disarm_mask),
    .en_o     (en_q)
  );

  eia_irq_out #(
    .N_SRC     (N_SRC),
    .FATAL_SEL (FATAL_SEL)
  ) u_out (
    .raw_i   (raw_q),
    .en_i    (en_q),
    .irq_o   (err_irq_o),
    .fatal_o (err_fatal_o)
  );

endmodule

// File: rtl/eia_err_irq_agg_chk.sv
module eia_err_irq_agg_chk
  import eia_pkg::*;
#(
  parameter int               N_SRC     = 6,
  parameter int               DATA_W    = 32,
  parameter int               ADDR_W    = 12,
  parameter logic [N_SRC-1:0] FATAL_SEL = 6'b01_0010
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [N_SRC-1:0]  err_evt_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              err_irq_o,
  input logic              err_fatal_o,
  input logic [N_SRC-1:0]  raw_q,
  input logic [N_SRC-1:0]  en_q
);

  logic wr_status;
  logic wr_arm;
  logic wr_disarm;

  assign wr_status = bus_wr_i &&
                     ((bus_addr_i == ADDR_W'(OFS_RAW)) ||
                      (bus_addr_i == ADDR_W'(OFS_MASKED)));
  assign wr_arm    = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_ARM));
  assign wr_disarm = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_DISARM));

  AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|err_evt_i) |=> ((raw_q & $past(err_evt_i)) == $past(err_evt_i))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_status |=>
      ((raw_q & $past(bus_wdata_i[N_SRC-1:0]) & ~$past(err_evt_i)) == '0)); // R4

  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_wr_i && (err_evt_i == '0)) |=> $stable(raw_q)); // R4

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_arm |=>
      ((en_q & $past(bus_wdata_i[N_SRC-1:0])) == $past(bus_wdata_i[N_SRC-1:0]))); // R5

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_disarm |=> ((en_q & $past(bus_wdata_i[N_SRC-1:0])) == '0)); // R5

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_irq_o == ((raw_q & en_q) != '0)); // R7

  AST_FATAL_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_fatal_o |-> err_irq_o); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata_o[DATA_W-1:N_SRC] == '0); // R9

endmodule

bind eia_err_irq_agg eia_err_irq_agg_chk #(
  .N_SRC     (N_SRC),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .FATAL_SEL (FATAL_SEL)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .err_evt_i   (err_evt_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .err_irq_o   (err_irq_o),
  .err_fatal_o (err_fatal_o),
  .raw_q       (raw_q),
  .en_q        (en_q)
);

// File: tb/tb_eia_err_irq_agg.sv
`timescale 1ns/1ps
module tb_eia_err_irq_agg;

  localparam int N_SRC  = 6;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_RAW    = 12'h1c0;
  localparam logic [ADDR_W-1:0] A_MASKED = 12'h1c4;
  localparam logic [ADDR_W-1:0] A_ARM    = 12'h1c8;
  localparam logic [ADDR_W-1:0] A_DISARM = 12'h1cc;
  localparam logic [ADDR_W-1:0] A_UNMAP  = 12'h1d0;
  localparam logic [5:0]        FATAL_BITS = 6'b01_0010;

  logic              clk;
  logic              rst_n;
  logic [N_SRC-1:0]  err_evt_i;
  logic [ADDR_W-1:0] bus_addr_i;
  logic              bus_wr_i;
  logic [DATA_W-1:0] bus_wdata_i;
  logic [DATA_W-1:0] bus_rdata_o;
  logic              err_irq_o;
  logic              err_fatal_o;

  int errors = 0;
  int checks = 0;

  eia_err_irq_agg dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_evt_i   (err_evt_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .err_irq_o   (err_irq_o),
    .err_fatal_o (err_fatal_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_wr_i    = 1'b1;
    @(negedge clk);
    bus_wr_i    = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    err_evt_i = p;
    @(negedge clk);
    err_evt_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n       = 1'b0;
    err_evt_i   = '0;
    bus_addr_i  = '0;
    bus_wr_i    = 1'b0;
    bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(A_RAW, d);    check("R1 raw", d, 0);
    rd(A_MASKED, d); check("R1 masked", d, 0);
    rd(A_ARM, d);    check("R1 enable", d, 0);
    check("R1 irq", {31'd0, err_irq_o}, 0);
    check("R1 fatal", {31'd0, err_fatal_o}, 0);

    // R2, R3, R7, R8: full sweep of enable word x event pattern
    for (int e = 0; e < 64; e++) begin
      wr(A_DISARM, 32'h3f);
      wr(A_ARM, 32'(e));
      rd(A_ARM, d);    check("R5 arm read", d, 32'(e));
      rd(A_DISARM, d); check("R5 disarm read", d, 32'(e));
      for (int p = 0; p < 64; p++) begin
        logic [5:0] m;
        wr(A_RAW, 32'h3f);
        pulse(6'(p));
        m = 6'(p) & 6'(e);
        rd(A_RAW, d);    check("R2 raw capture", d, 32'(p));
        rd(A_MASKED, d); check("R3 masked view", d, 32'(m));
        check("R7 irq", {31'd0, err_irq_o}, {31'd0, |m});
        check("R8 fatal", {31'd0, err_fatal_o}, {31'd0, |(m & FATAL_BITS)});
      end
    end

    // R4: selective clear through both offsets
    wr(A_ARM, 32'h3f);
    pulse(6'h3f);
    wr(A_RAW, 32'h05);
    rd(A_RAW, d); check("R4 clear via raw", d, 32'h3a);
    wr(A_MASKED, 32'h30);
    rd(A_RAW, d); check("R4 clear via masked", d, 32'h0a);
    repeat (4) @(negedge clk);
    rd(A_RAW, d); check("R4 hold", d, 32'h0a);

    // R5: accumulation and removal through aliases
    wr(A_DISARM, 32'h3f);
    wr(A_ARM, 32'h01);
    wr(A_ARM, 32'h20);
    rd(A_ARM, d); check("R5 arm accumulates", d, 32'h21);
    wr(A_DISARM, 32'h01);
    rd(A_DISARM, d); check("R5 disarm removes", d, 32'h20);
    wr(A_ARM, 32'h3f);
    rd(A_ARM, d); check("R5 all enabled", d, 32'h3f);

    // R6: event collides with its clear
    wr(A_RAW, 32'h3f);
    @(negedge clk);
    err_evt_i   = 6'h12;
    bus_addr_i  = A_RAW;
    bus_wdata_i = 32'h3f;
    bus_wr_i    = 1'b1;
    @(negedge clk);
    err_evt_i = '0;
    bus_wr_i  = 1'b0;
    rd(A_RAW, d); check("R6 event wins", d, 32'h12);
    check("R6 fatal asserted", {31'd0, err_fatal_o}, 1);

    // R9: upper data bits and unmapped offsets
    wr(A_DISARM, 32'h3f);
    wr(A_ARM, 32'hffff_ffc0);
    rd(A_ARM, d); check("R9 upper write ignored", d, 0);
    wr(A_UNMAP, 32'hffff_ffff);
    rd(A_ARM, d); check("R9 unmapped no enable", d, 0);
    rd(A_RAW, d); check("R9 unmapped no clear", d, 32'h12);
    rd(A_UNMAP, d); check("R9 unmapped reads zero", d, 0);
    wr(A_ARM, 32'h3f);
    rd(A_MASKED, d); check("R9 upper read zero", d & 32'hffff_ffc0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule